// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces one successive-approximation conversion at a time. The platform clock is divided by an even ratio set by a 5-bit prescaler code. The result is a single-cycle ADC clock enable that stays in the platform clock domain. Each accepted command opens a sampling window and then a conversion window, both counted in ADC clock enables. A one-cycle done pulse marks the end of the command.

The sampling window takes one of four lengths, picked by a 2-bit select. The conversion window is one cycle longer for single-ended inputs than for differential inputs. A prescaler code whose division ratio is below the `MIN_DIV` parameter raises a configuration error, and no command is taken while that error is present. The ADC clock enable runs only while a command is in progress. The divider starts from zero each time a command is accepted, so the timing from acceptance to done is fixed.

Top module: `adc_seq_timer`

## Requirements
- R1: The division ratio D equals 2*(ps_code+1). While a command runs, adc_ce pulses once every D clock cycles. The first pulse comes in the cycle that starts D-1 edges after the accepting edge.
- R2: smp_sel picks the number of sampling strobes: 0 gives 2, 1 gives 8, 2 gives 64, 3 gives 128.
- R3: A command issued with diff_mode=1 produces 13 conversion strobes. With diff_mode=0 it produces 14.
- R4: done is high for exactly one cycle. That cycle starts (S+C)*D edges after the accepting edge, where S is the sampling count and C is the conversion count.
- R5: cmd_ready is high only when the block is idle and cfg_err is low. It is low from the accepting edge through the done cycle, and it is high again in the cycle after done.
- R6: cfg_err is high when D is less than MIN_DIV (default 8, so codes 0 to 2 are in error and code 3 is not). While cfg_err is high, cmd_valid starts nothing.
- R7: While a command runs, changes to ps_code, smp_sel, diff_mode and cmd_valid have no effect on its timing or its strobe counts.
- R8: While idle, adc_ce, smp_phase and cnv_phase stay low.
- R9: A synchronous active-high reset ends any command in progress. No done pulse follows, and the block returns to idle with cmd_ready high for a legal code.
- R10: Each smp_phase or cnv_phase strobe falls in a cycle with adc_ce high. The two strobes are never high together, and every sampling strobe comes before the first conversion strobe.

Inputs are loaded into the configuration register in each idle cycle, so cfg_err and cmd_ready follow a change of ps_code one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Platform clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_code | input | 5 | Prescaler code; ratio 2*(code+1) |
| smp_sel | input | 2 | Sampling window select |
| diff_mode | input | 1 | 1 = differential, 0 = single-ended |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted |
| adc_ce | output | 1 | ADC clock enable, one cycle wide |
| smp_phase | output | 1 | Sampling strobe, one per sampling ADC clock |
| cnv_phase | output | 1 | Conversion strobe, one per conversion ADC clock |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Prescaler ratio below the legal minimum |

## Verification
Two functions can fall in the same cycle: the last sampling enable switches the phase counter to the conversion length, and the divider restarts its count on that same enable. Every table entry crosses this boundary. Any extra or lost cycle at the handover shows up as a wrong strobe count or a shifted done cycle. A command held on cmd_valid during a run, together with a changed prescaler code, tests whether a new load can happen in the same cycle as an enable from the running divider. The result is judged by the done cycle staying unchanged and cmd_ready staying low.

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int PS_W    = 5,
  parameter int MIN_DIV = 8,
  parameter int PH_W    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PS_W-1:0] ps_code,
  input  logic [1:0]      smp_sel,
  input  logic            diff_mode,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  output logic            adc_ce,
  output logic            smp_phase,
  output logic            cnv_phase,
  output logic            done,
  output logic            cfg_err
);
  localparam int DIV_W = PS_W + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_SMP, ST_CNV, ST_DONE} st_t;

  st_t             st;
  logic [PS_W-1:0] ps_q;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_fac;
  logic [PH_W-1:0] ph_cnt;
  logic [PH_W-1:0] cnv_last;
  logic [PH_W-1:0] smp_last;
  logic            busy;
  logic            accept;

  assign div_fac   = {1'b0, ps_q, 1'b0} + DIV_W'(2);
  assign cfg_err   = div_fac < DIV_W'(MIN_DIV);
  assign busy      = (st == ST_SMP) || (st == ST_CNV);
  assign adc_ce    = busy && (div_cnt == div_fac - DIV_W'(1));
  assign smp_phase = adc_ce && (st == ST_SMP);
  assign cnv_phase = adc_ce && (st == ST_CNV);
  assign done      = (st == ST_DONE);
  assign cmd_ready = (st == ST_IDLE) && !cfg_err;
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    case (smp_sel)
      2'd0:    smp_last = PH_W'(1);
      2'd1:    smp_last = PH_W'(7);
      2'd2:    smp_last = PH_W'(63);
      default: smp_last = PH_W'(127);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ps_q     <= ps_code;
      div_cnt  <= '0;
      ph_cnt   <= '0;
      cnv_last <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          ps_q    <= ps_code;
          div_cnt <= '0;
          if (accept) begin
            st       <= ST_SMP;
            ph_cnt   <= smp_last;
            cnv_last <= diff_mode ? PH_W'(12) : PH_W'(13);
          end
        end
        ST_SMP, ST_CNV: begin
          div_cnt <= adc_ce ? '0 : div_cnt + DIV_W'(1);
          if (adc_ce) begin
            if (ph_cnt != '0) begin
              ph_cnt <= ph_cnt - PH_W'(1);
            end else if (st == ST_SMP) begin
              st     <= ST_CNV;
              ph_cnt <= cnv_last;
            end else begin
              st <= ST_DONE;
            end
          end
        end
        default: begin
          st      <= ST_IDLE;
          div_cnt <= '0;
        end
      endcase
    end
  end
endmodule

module adc_seq_timer_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic adc_ce,
  input logic smp_phase,
  input logic cnv_phase,
  input logic done,
  input logic cfg_err
);
  AST_STROBE_ON_CE: assert property (@(posedge clk) disable iff (rst)
    (smp_phase || cnv_phase) |-> adc_ce); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(smp_phase && cnv_phase)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
  AST_DONE_AFTER_CNV: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(cnv_phase)); // R3
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !cmd_ready); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R5
  AST_NO_READY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_ready); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !adc_ce); // R8
endmodule

bind adc_seq_timer adc_seq_timer_chk chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .adc_ce(adc_ce), .smp_phase(smp_phase), .cnv_phase(cnv_phase),
  .done(done), .cfg_err(cfg_err)
);

// File: tb/adc_seq_timer_tb_top.sv
module adc_seq_timer_tb_top;
  logic clk = 0;
  logic rst = 1;
  logic [4:0] ps_code = 5'd3;
  logic [1:0] smp_sel = 2'd0;
  logic diff_mode = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready, adc_ce, smp_phase, cnv_phase, done, cfg_err;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int done_m, n_ce, n_smp, n_cnv, first_ce, off_grid, busy_rdy, order_bad;

  always #5 clk = ~clk;

  adc_seq_timer dut_i (
    .clk(clk), .rst(rst), .ps_code(ps_code), .smp_sel(smp_sel),
    .diff_mode(diff_mode), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .adc_ce(adc_ce), .smp_phase(smp_phase), .cnv_phase(cnv_phase),
    .done(done), .cfg_err(cfg_err)
  );

  // {code[39:35], sel[34:33], diff[32], smp[31:24], cnv[23:16], done_cycle[15:0]}
  localparam logic [39:0] VEC [0:5] = '{
    {5'd3,  2'd0, 1'b1, 8'd2,   8'd13, 16'd120},
    {5'd3,  2'd0, 1'b0, 8'd2,   8'd14, 16'd128},
    {5'd4,  2'd1, 1'b1, 8'd8,   8'd13, 16'd210},
    {5'd31, 2'd0, 1'b0, 8'd2,   8'd14, 16'd1024},
    {5'd5,  2'd2, 1'b1, 8'd64,  8'd13, 16'd924},
    {5'd3,  2'd3, 1'b0, 8'd128, 8'd14, 16'd1136}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic run_cmd(input logic [4:0] code, input logic [1:0] sel,
                         input logic dm, input bit disturb);
    int d;
    d = 2 * (code + 1);
    @(negedge clk);
    ps_code = code; smp_sel = sel; diff_mode = dm;
    @(negedge clk);
    chk(cmd_ready, "R5 ready before command", cmd_ready, 1);
    cmd_valid = 1'b1;
    @(posedge clk);
    done_m = -1; n_ce = 0; n_smp = 0; n_cnv = 0; first_ce = -1;
    off_grid = 0; busy_rdy = 0; order_bad = 0;
    for (int m = 0; m < 20000; m++) begin
      @(negedge clk);
      if (adc_ce) begin
        n_ce++;
        if (first_ce < 0) first_ce = m;
        if (((m + 1) % d) != 0) off_grid++;
      end
      if (smp_phase) begin
        n_smp++;
        if (n_cnv != 0) order_bad++;
      end
      if (cnv_phase) n_cnv++;
      if (cmd_ready) busy_rdy++;
      if (disturb) begin
        if (m == 0) begin ps_code = 5'd31; smp_sel = 2'd3; diff_mode = ~dm; end
        if (m == 3 * d) cmd_valid = 1'b0;
      end else if (m == 0) begin
        cmd_valid = 1'b0;
      end
      if (done) begin
        done_m = m;
        break;
      end
    end
    @(negedge clk);
    chk(!done, "R4 done one cycle", done, 0);
    ps_code = code;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(cmd_ready, "R9 ready after reset", cmd_ready, 1);
    chk(!cfg_err, "R9 no error for code 3", cfg_err, 0);
    chk(!done, "R9 done low after reset", done, 0);
    chk(!adc_ce, "R8 no enable while idle", adc_ce, 0);

    foreach (VEC[i]) begin
      int d, s, c, dn;
      d  = 2 * (VEC[i][39:35] + 1);
      s  = VEC[i][31:24];
      c  = VEC[i][23:16];
      dn = VEC[i][15:0];
      run_cmd(VEC[i][39:35], VEC[i][34:33], VEC[i][32], 1'b0);
      chk(done_m == dn, "R4 done cycle", done_m, dn);
      chk(n_smp == s, "R2 sampling strobes", n_smp, s);
      chk(n_cnv == c, "R3 conversion strobes", n_cnv, c);
      chk(n_ce == s + c, "R1 enable count", n_ce, s + c);
      chk(first_ce == d - 1, "R1 first enable", first_ce, d - 1);
      chk(off_grid == 0, "R1 enable spacing", off_grid, 0);
      chk(busy_rdy == 0, "R5 ready low while busy", busy_rdy, 0);
      chk(order_bad == 0, "R10 sampling before conversion", order_bad, 0);
      chk(cmd_ready, "R5 ready after done", cmd_ready, 1);
    end

    // R7: inputs changed and cmd_valid held during a run
    run_cmd(5'd3, 2'd0, 1'b1, 1'b1);
    chk(done_m == 120, "R7 done cycle unchanged", done_m, 120);
    chk(n_smp == 2, "R7 sampling count unchanged", n_smp, 2);
    chk(n_cnv == 13, "R7 conversion count unchanged", n_cnv, 13);
    chk(busy_rdy == 0, "R7 no accept while busy", busy_rdy, 0);

    // R6: illegal codes refuse commands
    begin
      int ev;
      @(negedge clk);
      ps_code = 5'd2;
      @(negedge clk);
      chk(cfg_err, "R6 error for code 2", cfg_err, 1);
      chk(!cmd_ready, "R6 ready low on error", cmd_ready, 0);
      cmd_valid = 1'b1;
      ev = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (adc_ce || done || smp_phase) ev++;
      end
      chk(ev == 0, "R6 no command started", ev, 0);
      ps_code = 5'd0;
      @(negedge clk);
      chk(cfg_err, "R6 error for code 0", cfg_err, 1);
      cmd_valid = 1'b0;
      ps_code = 5'd3;
      @(negedge clk);
      chk(!cfg_err, "R6 code 3 is legal", cfg_err, 0);
      chk(cmd_ready, "R6 ready for code 3", cmd_ready, 1);
    end

    // R9: reset in the middle of a run
    begin
      int ev;
      @(negedge clk);
      ps_code = 5'd3; smp_sel = 2'd1; diff_mode = 1'b0;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (30) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(cmd_ready, "R9 idle after mid-run reset", cmd_ready, 1);
      ev = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (done || adc_ce) ev++;
      end
      chk(ev == 0, "R9 no done after reset", ev, 0);
      chk(ev == 0, "R8 quiet while idle", ev, 0);
    end

    summary();
  end
endmodule